// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block runs an external serial 12-bit analog-to-digital converter from the system clock. It produces the two clocks the converter needs. The first is a conversion clock made by an integer divider. The second is a slow sample strobe that rises for one conversion-clock period ahead of each data burst. During the burst the converter shifts out a 16-bit word with its most significant bit first. The block samples each bit near the end of the low half of the conversion clock and drops the four leading initialization bits. It then offers the remaining 12-bit unsigned value to downstream processing.

The sample period is built from a whole number of conversion-clock periods, called slots. Slot 0 carries the strobe. Slots 1 to 16 carry the frame bits. Any further slots stay idle until the next strobe. The serial input passes through a short synchronizer before it is captured, so each conversion-clock half period must last longer than the synchronizer depth.

The output is a valid/ready stream. The converter cannot be stalled, so back-pressure only holds the newest sample. The held sample is replaced when the next frame completes. With ready held high, valid is a single-cycle pulse per sample.

Top module: `serial_adc_capture`

## Requirements
- R1: While `rst_n` is low, `adc_sclk` is 1, `adc_strobe` is 0, `smp_valid` is 0 and `smp_data` is 0.
- R2: `adc_sclk` toggles every `HALF_DIV` system clock cycles, giving a 50% duty cycle.
- R3: `adc_strobe` rises on a falling edge of `adc_sclk` and stays high for exactly one conversion-clock period (2*`HALF_DIV` cycles). Successive strobe rises are `SLOTS` falling edges of `adc_sclk` apart.
- R4: Frame bits are taken in the 16 conversion-clock periods that follow the strobe period, most significant bit first. Each bit is sampled from `adc_sdata` as it stands during the low half of `adc_sclk`, at least `SYNC_STAGES` cycles before the rising edge. No bit is taken while the strobe is high.
- R5: `smp_data` equals bits 11..0 of the 16-bit frame, where bit 15 is the first bit received. Frame bits 15..12 and any serial data outside the 16 frame periods have no effect on it.
- R6: `smp_valid` becomes 1 on the same clock edge on which `adc_sclk` rises after the 16th frame bit. It becomes 1 at no other time.
- R7: When `smp_ready` is 1, a sample is accepted and `smp_valid` drops on the next clock edge, so the valid pulse lasts one cycle.
- R8: While `smp_valid` is 1 and `smp_ready` is 0, `smp_valid` and `smp_data` hold steady until a new frame completes.
- R9: When a new frame completes while an older sample has not been accepted, the new sample replaces the old one and `smp_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Generated conversion clock, idles high |
| adc_strobe | output | 1 | Sample strobe, high for one conversion period per sample |
| smp_data | output | SAMPLE_BITS (12) | Captured unsigned sample |
| smp_valid | output | 1 | Sample valid (stream valid) |
| smp_ready | input | 1 | Downstream ready (stream ready) |

## Verification
A sample is due on the first clock edge at which `adc_sclk` rises after the model has driven the 16th frame bit. Serial bits change only on the cycle after `adc_sclk` falls, so the synchronizer delay falls inside the low half period. The bench watches outputs on the falling system-clock edge. It compares every clock and strobe transition with the previous one: `HALF_DIV` cycles between clock toggles, 2*`HALF_DIV` cycles of strobe, and `SLOTS` falling edges per sample. The ready value the design saw is captured at the rising edge. Hold and one-cycle-pulse checks use it together with the known capture edge to decide what the next cycle must show.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int FRAME_LEN  = 16;
  localparam int SAMPLE_LEN = 12;
  localparam int LEAD_LEN   = FRAME_LEN - SAMPLE_LEN;
endpackage

// File: rtl/sadc_clk_div.sv
module sadc_clk_div #(
  parameter int HALF_DIV = 820
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // events coincide with the edge on which sclk changes
  assign fall_ev = tick & sclk;
  assign rise_ev = tick & ~sclk;
endmodule

// File: rtl/sadc_slot_seq.sv
module sadc_slot_seq #(
  parameter int SLOTS     = 20,
  parameter int FRAME_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic fall_ev,
  input  logic rise_ev,
  output logic strobe,
  output logic cap_en,
  output logic last_bit
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] SLOT_LAST  = SW'(SLOTS - 1);
  localparam logic [SW-1:0] SLOT_FRAME = SW'(FRAME_LEN);

  logic [SW-1:0] slot;
  logic [SW-1:0] slot_nxt;

  assign slot_nxt = (slot == SLOT_LAST) ? '0 : slot + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= SLOT_LAST;
      strobe <= 1'b0;
    end else if (fall_ev) begin
      slot   <= slot_nxt;
      strobe <= (slot_nxt == '0);
    end
  end

  assign cap_en   = rise_ev && (slot != '0) && (slot <= SLOT_FRAME);
  assign last_bit = rise_ev && (slot == SLOT_FRAME);

  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe) |-> $fell(sclk)); // R3
endmodule

// File: rtl/sadc_shift_in.sv
module sadc_shift_in #(
  parameter int SAMPLE_LEN  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sdata,
  input  logic                  cap_en,
  output logic [SAMPLE_LEN-1:0] word
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SAMPLE_LEN-2:0]  shreg;
  logic                   bit_in;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sdata;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sdata};
      end
    end
  endgenerate

  assign bit_in = sync_q[SYNC_STAGES-1];

  // leading bits shift out the top and are lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shreg <= '0;
    else if (cap_en) shreg <= {shreg[SAMPLE_LEN-3:0], bit_in};
  end

  assign word = {shreg, bit_in};
endmodule

// File: rtl/sadc_out_reg.sv
module sadc_out_reg #(
  parameter int SAMPLE_LEN = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [SAMPLE_LEN-1:0] din,
  output logic [SAMPLE_LEN-1:0] data,
  output logic                  valid,
  input  logic                  ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      data  <= din;
      valid <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data))); // R8
endmodule

// File: rtl/serial_adc_capture.sv
module serial_adc_capture #(
  parameter int HALF_DIV    = 820,
  parameter int SLOTS       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = sadc_pkg::FRAME_LEN,
  parameter int SAMPLE_BITS = sadc_pkg::SAMPLE_LEN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adc_sdata,
  output logic                   adc_sclk,
  output logic                   adc_strobe,
  output logic [SAMPLE_BITS-1:0] smp_data,
  output logic                   smp_valid,
  input  logic                   smp_ready
);
  logic                   fall_ev;
  logic                   rise_ev;
  logic                   cap_en;
  logic                   last_bit;
  logic [SAMPLE_BITS-1:0] word;

  sadc_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (adc_sclk),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  sadc_slot_seq #(.SLOTS(SLOTS), .FRAME_LEN(FRAME_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (adc_sclk),
    .fall_ev  (fall_ev),
    .rise_ev  (rise_ev),
    .strobe   (adc_strobe),
    .cap_en   (cap_en),
    .last_bit (last_bit)
  );

  sadc_shift_in #(.SAMPLE_LEN(SAMPLE_BITS), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sdata  (adc_sdata),
    .cap_en (cap_en),
    .word   (word)
  );

  sadc_out_reg #(.SAMPLE_LEN(SAMPLE_BITS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (last_bit),
    .din   (word),
    .data  (smp_data),
    .valid (smp_valid),
    .ready (smp_ready)
  );

  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $rose(adc_sclk)); // R6
  AST_NO_CAPTURE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !adc_strobe); // R4
  AST_STROBE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_strobe) |-> !adc_sclk); // R3
endmodule

// File: tb/serial_adc_capture_tb.sv
module serial_adc_capture_tb;
  localparam int HALF = 3;
  localparam int SL   = 18;
  localparam int FP   = 2 * HALF * SL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adc_sdata = 1'b0;
  logic        adc_sclk;
  logic        adc_strobe;
  logic [11:0] smp_data;
  logic        smp_valid;
  logic        smp_ready = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  int n_over   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  serial_adc_capture #(.HALF_DIV(HALF), .SLOTS(SL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .adc_sdata(adc_sdata), .adc_sclk(adc_sclk),
    .adc_strobe(adc_strobe), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] make_frame(input int idx);
    case (idx)
      0: make_frame = 16'hF000;
      1: make_frame = 16'h0FFF;
      2: make_frame = 16'h5A5A;
      3: make_frame = 16'hFFFF;
      4: make_frame = 16'h0001;
      default: make_frame = 16'($urandom);
    endcase
  endfunction

  function automatic int expect_of(input logic [15:0] f);
    expect_of = int'(f[11:0]);
  endfunction

  logic        rdy_seen;
  always @(posedge clk) rdy_seen <= smp_ready;

  logic [15:0] cur;
  int  pos = -1, since = 0, hi_len = 0, falls = 0, fidx = 0;
  bit  awaiting = 0, have_tog = 0, have_stb = 0;
  bit  p_sclk = 1, p_stb = 0, p_valid = 0;
  logic [11:0] p_data = '0;

  always @(negedge clk) begin
    bit rise, fall, load_now;
    if (!rst_n) begin
      chk(adc_sclk && !adc_strobe && !smp_valid && smp_data == 12'd0, "R1",
          {adc_sclk, adc_strobe, smp_valid}, 3'b100);
      pos = -1; awaiting = 0; have_tog = 0; have_stb = 0; since = 0;
      hi_len = 0; falls = 0;
      p_sclk = 1; p_stb = 0; p_valid = 0; p_data = '0;
    end else begin
      rise = adc_sclk && !p_sclk;
      fall = !adc_sclk && p_sclk;
      load_now = rise && awaiting;
      // R2 half-period spacing
      since++;
      if (rise || fall) begin
        if (have_tog) chk(since == HALF, "R2", since, HALF);
        have_tog = 1; since = 0;
      end
      // R3 strobe width and spacing
      if (fall) falls++;
      if (adc_strobe) hi_len++;
      if (adc_strobe && !p_stb) begin
        chk(fall, "R3 strobe on fall", fall, 1);
        if (have_stb) chk(falls == SL, "R3 slots", falls, SL);
        have_stb = 1; falls = 0;
      end
      if (!adc_strobe && p_stb) begin
        chk(hi_len == 2 * HALF, "R3 width", hi_len, 2 * HALF);
        hi_len = 0;
      end
      // R6 valid only at capture edge
      if (smp_valid && !p_valid && !load_now) chk(0, "R6 stray valid", 1, 0);
      if (load_now) begin
        chk(smp_valid, "R6", smp_valid, 1);
        chk(int'(smp_data) == expect_of(cur), "R5", smp_data, expect_of(cur));
        if (p_valid && !rdy_seen) begin
          n_over++;
          chk(int'(smp_data) == expect_of(cur), "R9 overwrite", smp_data, expect_of(cur));
        end
        awaiting = 0;
      end else begin
        if (p_valid && rdy_seen) chk(!smp_valid, "R7", smp_valid, 0);
        if (p_valid && !rdy_seen)
          chk(smp_valid && smp_data == p_data, "R8", smp_data, p_data);
      end
      // converter model: bits change just after the falling edge
      if (fall) begin
        if (adc_strobe) begin
          cur = make_frame(fidx); fidx++;
          pos = 15;
          adc_sdata = 1'($urandom);
        end else if (pos >= 0) begin
          adc_sdata = cur[pos];       // R4 MSB first
          if (pos == 0) awaiting = 1;
          pos--;
        end else begin
          adc_sdata = 1'($urandom);   // R5 idle-slot noise ignored
        end
      end
      p_sclk = adc_sclk; p_stb = adc_strobe; p_valid = smp_valid; p_data = smp_data;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h1F2E3D);
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (40 * FP) @(posedge clk);
    repeat (80 * FP) begin
      @(posedge clk);
      #2 smp_ready = (($urandom % 4) != 0);
    end
    @(posedge clk);
    #2 smp_ready = 1'b0;
    repeat (3 * FP) @(posedge clk);
    #2 smp_ready = 1'b1;
    repeat (FP + FP / 2) @(posedge clk);
    #2 rst_n = 1'b0;
    repeat (6) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (30 * FP) @(posedge clk);
    chk(n_over > 0, "R9 overwrite seen", n_over, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule